// File: doc/BRIEF.md
# Hysteresis Buffer-Request FIFO

A synchronous first-in first-out store of 32-bit words that also drives a single request line toward a shared memory buffer. The request line has hysteresis on the fill level: it switches on at one trip point and off at another, and holds its value between them. This keeps the buffer arbiter from seeing a request that toggles on every word.

A mode input selects which pair of trip points is used. In fill mode the FIFO is a consumer of buffer data, as on a host link. The request rises when the store runs empty and drops once the almost-full level is reached. In drain mode the FIFO is a producer toward the buffer, as on a media channel. The request rises at almost full and stays high until the store is empty.

The depth is a per-instance parameter, a multiple of 8 from 8 to 128 words, so two instances can be sized independently. The almost-full threshold is an input that can change at run time. A write into a full store is dropped and recorded in a sticky overflow flag.

Top module: `hyst_req_fifo`

## Requirements
- R1: While reset is high and on the first cycle after it, level is 0, empty is 1, full, almost_full and overflow are 0, and xfer_req equals 1 in fill mode (drain_mode=0) and 0 in drain mode (drain_mode=1).
- R2: Words are read in the order they were written. rd_data presents the word taken by a read strobe on the clock edge that accepts that strobe, and it holds its value otherwise.
- R3: An accepted write raises level by one and an accepted read lowers it by one. A read and a write in the same cycle while neither full nor empty leave level unchanged.
- R4: full is 1 exactly when level equals DEPTH. A write while full is dropped, so level and the stored words are unchanged.
- R5: A write attempted while full sets overflow, which stays 1 until ovf_clear is pulsed. When a new overflow and ovf_clear occur in the same cycle, the set wins.
- R6: A read strobe while empty is ignored: level stays 0 and rd_data keeps its value.
- R7: almost_full is 1 when level >= thr. A thr of 0 acts as 1, and a thr above DEPTH acts as DEPTH.
- R8: In fill mode xfer_req becomes 1 when level reaches 0 and becomes 0 when almost_full becomes 1. It keeps its value for levels in between.
- R9: In drain mode xfer_req becomes 1 when almost_full becomes 1 and becomes 0 when level reaches 0. It keeps its value for levels in between.
- R10: level, the flags and xfer_req all change on the same clock edge that accepts the read or write causing the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drain_mode | input | 1 | 0 = fill mode, 1 = drain mode |
| thr | input | CW | Almost-full threshold in words |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Word to write |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Word read, registered |
| level | output | CW | Words currently stored |
| empty | output | 1 | Level is 0 |
| full | output | 1 | Level is DEPTH |
| almost_full | output | 1 | Level at or above the threshold |
| overflow | output | 1 | Sticky flag for a write attempted while full |
| ovf_clear | input | 1 | Clears overflow |
| xfer_req | output | 1 | Hysteresis request toward the buffer |

## Verification
The fill-mode request is driven by a sequence that climbs to the threshold, goes back down through it with a mixed read/write cycle in the middle, reaches empty, and climbs again. This distinguishes real hysteresis from a request that is just a level compare, because the request must stay put on both sides between the trip points. Drain mode is run through the same climb and descent, which shows that the two trip points are swapped. The store is filled past its depth to check that the extra word never comes out and that the overflow flag is sticky, set-wins and clearable. Threshold values of 0 and above the depth check the clamping at both ends.

// File: rtl/hrf_pkg.sv
package hrf_pkg;
  typedef enum logic {
    MODE_FILL  = 1'b0,
    MODE_DRAIN = 1'b1
  } xfer_mode_e;
endpackage

// File: rtl/hrf_store.sv
module hrf_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // simple dual-port array with a registered read port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/hrf_ctrl.sv
module hrf_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [CW-1:0] thr,
  input  logic          ovf_clear,
  output logic          do_wr,
  output logic          do_rd,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          almost_full,
  output logic          overflow,
  output logic          empty_n,
  output logic          af_n
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_C  = AW'(DEPTH - 1);

  logic [CW-1:0] cnt_n, thr_eff;

  always_comb begin
    do_wr = wr_en & ~full;
    do_rd = rd_en & ~empty;
    cnt_n = level;
    if (do_wr && !do_rd)      cnt_n = level + 1'b1;
    else if (do_rd && !do_wr) cnt_n = level - 1'b1;
    if (thr == '0)            thr_eff = CW'(1);
    else if (thr > DEPTH_C)   thr_eff = DEPTH_C;
    else                      thr_eff = thr;
    empty_n = (cnt_n == '0);
    af_n    = (cnt_n >= thr_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr        <= '0;
      rptr        <= '0;
      level       <= '0;
      empty       <= 1'b1;
      full        <= 1'b0;
      almost_full <= 1'b0;
      overflow    <= 1'b0;
    end else begin
      if (do_wr) wptr <= (wptr == LAST_C) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == LAST_C) ? '0 : rptr + 1'b1;
      level       <= cnt_n;
      empty       <= empty_n;
      full        <= (cnt_n == DEPTH_C);
      almost_full <= af_n;
      if (wr_en && full)  overflow <= 1'b1;
      else if (ovf_clear) overflow <= 1'b0;
    end
  end

  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= DEPTH_C);
  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> $stable(level));
  // R3
  mixed_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en && !full && !empty) |=> $stable(level));
  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (overflow && !ovf_clear) |=> overflow);
  // R6
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && empty) |=> (level == '0));
endmodule

// File: rtl/hrf_req.sv
module hrf_req
  import hrf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic drain_mode,
  input  logic empty_n,
  input  logic af_n,
  input  logic empty_q,
  input  logic af_q,
  output logic req
);
  xfer_mode_e mode;
  assign mode = xfer_mode_e'(drain_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      req <= (mode == MODE_FILL);
    end else if (mode == MODE_FILL) begin
      if (empty_n)   req <= 1'b1;
      else if (af_n) req <= 1'b0;
    end else begin
      if (af_n)         req <= 1'b1;
      else if (empty_n) req <= 1'b0;
    end
  end

  // R8
  fill_on_chk: assert property (@(posedge clk) disable iff (rst)
    (!drain_mode && $stable(drain_mode) && empty_q) |-> req);
  // R8
  fill_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!drain_mode && $stable(drain_mode) && af_q && !empty_q) |-> !req);
  // R9
  drain_on_chk: assert property (@(posedge clk) disable iff (rst)
    (drain_mode && $stable(drain_mode) && af_q) |-> req);
  // R9
  drain_off_chk: assert property (@(posedge clk) disable iff (rst)
    (drain_mode && $stable(drain_mode) && empty_q && !af_q) |-> !req);
endmodule

// File: rtl/hyst_req_fifo.sv
module hyst_req_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          drain_mode,
  input  logic [CW-1:0] thr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          almost_full,
  output logic          overflow,
  input  logic          ovf_clear,
  output logic          xfer_req
);
  logic          do_wr, do_rd, empty_n, af_n;
  logic [AW-1:0] wptr, rptr;

  hrf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .thr(thr),
    .ovf_clear(ovf_clear), .do_wr(do_wr), .do_rd(do_rd),
    .wptr(wptr), .rptr(rptr), .level(level), .empty(empty),
    .full(full), .almost_full(almost_full), .overflow(overflow),
    .empty_n(empty_n), .af_n(af_n)
  );

  hrf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(do_wr), .waddr(wptr), .wdata(wr_data),
    .re(do_rd), .raddr(rptr), .rdata(rd_data)
  );

  hrf_req u_req (
    .clk(clk), .rst(rst), .drain_mode(drain_mode),
    .empty_n(empty_n), .af_n(af_n), .empty_q(empty),
    .af_q(almost_full), .req(xfer_req)
  );

  // R4
  full_level_chk: assert property (@(posedge clk) disable iff (rst)
    full == (level == CW'(DEPTH)));
endmodule

// File: tb/hyst_req_fifo_test.sv
`timescale 1ns/1ps
module hyst_req_fifo_test;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          drain_mode = 1'b0;
  logic [CW-1:0] thr = CW'(4);
  logic          wr_en = 1'b0, rd_en = 1'b0, ovf_clear = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic [CW-1:0] level;
  logic          empty, full, almost_full, overflow, xfer_req;

  int errs = 0, checks = 0;
  logic [31:0] model_q[$];
  logic [31:0] last_rd;

  always #2 clk = ~clk;

  hyst_req_fifo #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .drain_mode(drain_mode), .thr(thr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .level(level), .empty(empty), .full(full), .almost_full(almost_full),
    .overflow(overflow), .ovf_clear(ovf_clear), .xfer_req(xfer_req)
  );

  // {wr, rd, data byte, level, almost_full, xfer_req}, fill mode, threshold 4
  localparam int NV = 12;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'h11, 5'd1, 1'b0, 1'b1},
    {1'b1, 1'b0, 8'h22, 5'd2, 1'b0, 1'b1},
    {1'b1, 1'b0, 8'h33, 5'd3, 1'b0, 1'b1},
    {1'b1, 1'b0, 8'h44, 5'd4, 1'b1, 1'b0},
    {1'b0, 1'b1, 8'h00, 5'd3, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'h55, 5'd3, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h00, 5'd2, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h00, 5'd1, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h00, 5'd0, 1'b0, 1'b1},
    {1'b1, 1'b0, 8'h66, 5'd1, 1'b0, 1'b1},
    {1'b1, 1'b1, 8'h77, 5'd1, 1'b0, 1'b1},
    {1'b0, 1'b1, 8'h00, 5'd0, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // one cycle of traffic; rd_data checked against the order of writes (R2)
  task automatic op(input logic w, input logic r, input logic [31:0] d);
    logic acc_w, acc_r;
    acc_w = w && (model_q.size() < DEPTH);
    acc_r = r && (model_q.size() > 0);
    wr_en = w; rd_en = r; wr_data = d;
    tick();
    wr_en = 1'b0; rd_en = 1'b0;
    if (acc_r) last_rd = model_q.pop_front();
    if (acc_w) model_q.push_back(d);
    if (r) chk("R2 rd_data", rd_data, last_rd);
    chk("R3 level", 32'(level), 32'(model_q.size()));
  endtask

  task automatic do_reset(input logic dm);
    drain_mode = dm; rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    model_q.delete();
  endtask

  initial begin
    #800000;
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    last_rd = '0;
    // R1 fill-mode reset state
    do_reset(1'b0);
    chk("R1 level", 32'(level), 0);
    chk("R1 empty", 32'(empty), 1);
    chk("R1 full", 32'(full), 0);
    chk("R1 almost_full", 32'(almost_full), 0);
    chk("R1 overflow", 32'(overflow), 0);
    chk("R1 fill req", 32'(xfer_req), 1);

    // R8 R7 R3 R10 table walk
    for (int i = 0; i < NV; i++) begin
      op(VEC[i][16], VEC[i][15], {4{VEC[i][14:7]}});
      chk("R10 level", 32'(level), 32'(VEC[i][6:2]));
      chk("R7 almost_full", 32'(almost_full), 32'(VEC[i][1]));
      chk("R8 fill req", 32'(xfer_req), 32'(VEC[i][0]));
    end

    // R6 read while empty
    op(1'b0, 1'b1, 32'h0);
    chk("R6 level", 32'(level), 0);
    chk("R6 rd_data", rd_data, 32'h77777777);

    // R9 drain mode
    do_reset(1'b1);
    chk("R1 drain req", 32'(xfer_req), 0);
    for (int i = 0; i < 3; i++) op(1'b1, 1'b0, 32'hA0 + 32'(i));
    chk("R9 below thr", 32'(xfer_req), 0);
    op(1'b1, 1'b0, 32'hA3);
    chk("R9 at thr", 32'(xfer_req), 1);
    chk("R7 af at thr", 32'(almost_full), 1);
    for (int i = 0; i < 3; i++) op(1'b0, 1'b1, 32'h0);
    chk("R9 hold", 32'(xfer_req), 1);
    op(1'b0, 1'b1, 32'h0);
    chk("R9 empty off", 32'(xfer_req), 0);
    chk("R2 drain last", rd_data, 32'hA3);

    // R4 R5 full and overflow
    do_reset(1'b0);
    for (int i = 0; i < DEPTH; i++) op(1'b1, 1'b0, 32'h100 + 32'(i));
    chk("R4 full", 32'(full), 1);
    op(1'b1, 1'b0, 32'hDEAD);
    chk("R4 level kept", 32'(level), DEPTH);
    chk("R5 overflow set", 32'(overflow), 1);
    for (int i = 0; i < DEPTH; i++) op(1'b0, 1'b1, 32'h0);
    chk("R4 last word", rd_data, 32'h10F);
    chk("R5 sticky", 32'(overflow), 1);
    ovf_clear = 1'b1; tick(); ovf_clear = 1'b0;
    chk("R5 cleared", 32'(overflow), 0);
    for (int i = 0; i < DEPTH; i++) op(1'b1, 1'b0, 32'h200);
    wr_en = 1'b1; ovf_clear = 1'b1; tick(); wr_en = 1'b0; ovf_clear = 1'b0;
    chk("R5 set wins", 32'(overflow), 1);

    // R7 threshold clamping
    do_reset(1'b0);
    thr = '0; tick();
    op(1'b1, 1'b0, 32'h1);
    chk("R7 thr0 as 1", 32'(almost_full), 1);
    thr = CW'(31); tick();
    chk("R7 thr high off", 32'(almost_full), 0);
    for (int i = 1; i < DEPTH - 1; i++) op(1'b1, 1'b0, 32'h2);
    chk("R7 thr high below", 32'(almost_full), 0);
    op(1'b1, 1'b0, 32'h3);
    chk("R7 thr high at depth", 32'(almost_full), 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule